// File: doc/BRIEF.md
# Scaler Interrupt Request Controller

This block collects up to eight event lines from a counting front end and turns them into a single interrupt request. Typical lines are a per-bin transfer pulse, an end-of-acquisition signal and a counter-overflow condition. Each line is either edge-sensitive or level-sensitive, chosen per source by a parameter mask.

Each source has three pieces of state: a latched flag, an individual enable and a clear action. A single configuration word holds four settings: the interrupt vector, the request level, a global enable and the acknowledge mode. Software reaches both words through a small 32-bit register port.

When the handler acknowledges the request, the block returns the vector. In release-on-acknowledge mode the acknowledge also drops the enable of every source that caused the request. Software must re-enable those sources after servicing them. In the other mode the request persists until software clears or disables the causing source.

Top module: `scaler_irq_ctrl`

## Requirements
- R1: After reset, irq_o, irq_level_o and vec_valid_o are 0, and both registers read 0.
- R2: The configuration word (address 0) holds the vector in bits 7:0, the level in bits 10:8, the global enable in bit 11 and the mode in bit 12 (1 = release on acknowledge). It reads back exactly, and bits 31:13 read 0.
- R3: Writing the control word (address 1) has two enable actions. A 1 in bit n sets the enable of source n, and a 1 in bit 8+n clears it. Enables read back in bits 7:0, and bits 15:8 read 0.
- R4: An edge-sensitive source sets its flag on the clock edge where its input is first seen high. The flag stays set after the input falls, until a 1 is written to control bit 16+n. Flags read back in bits 23:16.
- R5: A level-sensitive source (source 3 by default) has a flag that follows its input one clock later. Writing its clear bit has no effect while the input is high.
- R6: irq_o goes high one clock after the flag of an enabled source is set, but only when the global enable is 1 and the level is non-zero. Otherwise it stays low.
- R7: irq_level_o equals the configured level while irq_o is high, and is 0 otherwise.
- R8: Consider an ack_i that is sampled while irq_o is high. One clock later, vec_valid_o is high for one cycle and vec_o carries the configured vector.
- R9: In release-on-acknowledge mode, an acknowledge clears the enables of all flagged sources and leaves their flags set. Other enables are left unchanged. irq_o falls one clock after vec_valid_o rises.
- R10: In the other mode, an acknowledge changes no enable, and irq_o stays high until the flag is cleared.
- R11: An ack_i sampled while irq_o is low produces no vector and changes no enable.
- R12: Bit 31 of the control word reads the current value of irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; data appears next cycle |
| addr_i | input | ADDR_W | Register address (0 config, 1 control) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| src_i | input | N_SRC | Interrupt source lines |
| ack_i | input | 1 | Interrupt acknowledge |
| irq_o | output | 1 | Interrupt request |
| irq_level_o | output | 3 | Level of the pending request |
| vec_o | output | 8 | Vector returned on acknowledge |
| vec_valid_o | output | 1 | One-cycle strobe qualifying vec_o |

## Verification
The bench sweeps every source in both acknowledge modes, with a different vector and level on each pass. This shows that only the selected source raises the request, and that the vector and level track the configuration. Pulsed inputs on edge sources separate sticky latching from level following. A held input on the level source shows that its clear is refused. Acknowledge with and without a pending request separates the two release modes from a stray acknowledge. Gating by the global enable and by a zero level is tried with a flag already pending.

// File: rtl/scaler_irq_pkg.sv
package scaler_irq_pkg;
  localparam int VEC_W        = 8;
  localparam int LVL_W        = 3;
  localparam int DATA_W       = 32;
  // configuration word field positions
  localparam int CFG_LVL_LSB  = 8;
  localparam int CFG_GEN_BIT  = 11;
  localparam int CFG_ROAK_BIT = 12;
  // control word field positions
  localparam int CSR_DIS_LSB  = 8;
  localparam int CSR_CLR_LSB  = 16;
  localparam int CSR_IRQ_BIT  = 31;
  localparam int ADDR_CFG     = 0;
  localparam int ADDR_CSR     = 1;

  typedef struct packed {
    logic             roak;
    logic             gen;
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } irq_cfg_t;
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell #(
  parameter bit EDGE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic src_i,
  input  logic clr_i,
  output logic flag_o
);
  generate
    if (EDGE) begin : g_edge
      logic src_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          src_q  <= 1'b0;
          flag_o <= 1'b0;
        end else begin
          src_q  <= src_i;
          // a new rising edge wins over a clear in the same cycle
          flag_o <= (src_i & ~src_q) | (flag_o & ~clr_i);
        end
      end
    end else begin : g_level
      logic unused_clr;
      assign unused_clr = clr_i;
      always_ff @(posedge clk) begin
        if (rst) flag_o <= 1'b0;
        else     flag_o <= src_i;
      end
    end
  endgenerate
endmodule

// File: rtl/irq_regs.sv
module irq_regs
  import scaler_irq_pkg::*;
#(
  parameter int N_SRC  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              take_i,
  input  logic [N_SRC-1:0]  flag_i,
  input  logic              irq_i,
  output irq_cfg_t          cfg_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  clr_o
);
  logic             wr_cfg, wr_csr;
  logic [N_SRC-1:0] en_next;
  logic [DATA_W-1:0] rd_mux;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;
  assign wr_cfg = wr_en_i && (addr_i == ADDR_W'(ADDR_CFG));
  assign wr_csr = wr_en_i && (addr_i == ADDR_W'(ADDR_CSR));
  assign clr_o  = wr_csr ? wdata_i[CSR_CLR_LSB +: N_SRC] : '0;

  always_comb begin
    en_next = en_o;
    if (take_i && cfg_o.roak) en_next = en_next & ~flag_i;
    // a software write in the same cycle takes precedence
    if (wr_csr) en_next = (en_next | wdata_i[0 +: N_SRC]) & ~wdata_i[CSR_DIS_LSB +: N_SRC];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_o <= '0;
      en_o  <= '0;
    end else begin
      en_o <= en_next;
      if (wr_cfg) begin
        cfg_o.vec  <= wdata_i[VEC_W-1:0];
        cfg_o.lvl  <= wdata_i[CFG_LVL_LSB +: LVL_W];
        cfg_o.gen  <= wdata_i[CFG_GEN_BIT];
        cfg_o.roak <= wdata_i[CFG_ROAK_BIT];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(ADDR_CFG)) begin
      rd_mux[VEC_W-1:0]              = cfg_o.vec;
      rd_mux[CFG_LVL_LSB +: LVL_W]   = cfg_o.lvl;
      rd_mux[CFG_GEN_BIT]            = cfg_o.gen;
      rd_mux[CFG_ROAK_BIT]           = cfg_o.roak;
    end else if (addr_i == ADDR_W'(ADDR_CSR)) begin
      rd_mux[0 +: N_SRC]             = en_o;
      rd_mux[CSR_CLR_LSB +: N_SRC]   = flag_i;
      rd_mux[CSR_IRQ_BIT]            = irq_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= rd_mux;
  end
endmodule

// File: rtl/irq_req.sv
module irq_req
  import scaler_irq_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gen_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic [N_SRC-1:0] flag_i,
  input  logic             ack_i,
  output logic             irq_o,
  output logic [LVL_W-1:0] level_o,
  output logic [VEC_W-1:0] vec_o,
  output logic             vec_valid_o,
  output logic             take_o
);
  logic fire;

  assign fire   = gen_i && (lvl_i != '0) && (|(en_i & flag_i));
  assign take_o = ack_i && irq_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o       <= 1'b0;
      level_o     <= '0;
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
    end else begin
      irq_o       <= fire;
      level_o     <= fire ? lvl_i : '0;
      vec_valid_o <= take_o;
      if (take_o) vec_o <= vec_i;
    end
  end
endmodule

// File: rtl/scaler_irq_ctrl.sv
module scaler_irq_ctrl
  import scaler_irq_pkg::*;
#(
  parameter int             N_SRC     = 8,  // at most 8
  parameter int             ADDR_W    = 2,
  parameter logic [N_SRC-1:0] EDGE_MASK = 8'hF7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  src_i,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [LVL_W-1:0]  irq_level_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o
);
  irq_cfg_t         cfg;
  logic [N_SRC-1:0] en_q, flag_q, clr_w;
  logic             take;
  logic             cfg_roak, cfg_gen;

  assign cfg_roak = cfg.roak;
  assign cfg_gen  = cfg.gen;

  irq_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .take_i(take), .flag_i(flag_q), .irq_i(irq_o),
    .cfg_o(cfg), .en_o(en_q), .clr_o(clr_w)
  );

  generate
    for (genvar n = 0; n < N_SRC; n++) begin : g_src
      irq_src_cell #(.EDGE(EDGE_MASK[n])) u_cell (
        .clk(clk), .rst(rst), .src_i(src_i[n]), .clr_i(clr_w[n]), .flag_o(flag_q[n])
      );
    end
  endgenerate

  irq_req #(.N_SRC(N_SRC)) u_req (
    .clk(clk), .rst(rst), .gen_i(cfg.gen), .lvl_i(cfg.lvl), .vec_i(cfg.vec),
    .en_i(en_q), .flag_i(flag_q), .ack_i(ack_i),
    .irq_o(irq_o), .level_o(irq_level_o), .vec_o(vec_o),
    .vec_valid_o(vec_valid_o), .take_o(take)
  );
endmodule

// File: rtl/scaler_irq_ctrl_chk.sv
module scaler_irq_ctrl_chk
  import scaler_irq_pkg::*;
#(
  parameter int               N_SRC     = 8,
  parameter int               ADDR_W    = 2,
  parameter logic [N_SRC-1:0] EDGE_MASK = 8'hF7
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [N_SRC-1:0]  src_i,
  input logic              ack_i,
  input logic              irq_o,
  input logic [LVL_W-1:0]  irq_level_o,
  input logic              vec_valid_o,
  input logic [N_SRC-1:0]  en_q,
  input logic [N_SRC-1:0]  flag_q,
  input logic              cfg_roak,
  input logic              cfg_gen
);
  logic wr_csr;
  assign wr_csr = wr_en_i && (addr_i == ADDR_W'(ADDR_CSR));

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_o && !vec_valid_o));

  assert_gen_gates_R6: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(cfg_gen));

  assert_level_idle_R7: assert property (@(posedge clk) disable iff (rst)
    !irq_o |-> (irq_level_o == '0));

  assert_vec_after_ack_R8: assert property (@(posedge clk) disable iff (rst)
    vec_valid_o |-> $past(ack_i && irq_o));

  assert_roak_disables_R9: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && cfg_roak && !wr_csr) |=> ((en_q & $past(flag_q)) == '0));

  assert_rora_keeps_R10: assert property (@(posedge clk) disable iff (rst)
    (ack_i && irq_o && !cfg_roak && !wr_csr) |=> (en_q == $past(en_q)));

  assert_stray_ack_R11: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !irq_o) |=> !vec_valid_o);

  generate
    for (genvar n = 0; n < N_SRC; n++) begin : g_chk
      if (EDGE_MASK[n]) begin : g_edge
        assert_edge_sticky_R4: assert property (@(posedge clk) disable iff (rst)
          (flag_q[n] && !(wr_csr && wdata_i[CSR_CLR_LSB + n])) |=> flag_q[n]);
      end else begin : g_level
        assert_level_follow_R5: assert property (@(posedge clk) disable iff (rst)
          1'b1 |=> (flag_q[n] == $past(src_i[n])));
      end
    end
  endgenerate
endmodule

bind scaler_irq_ctrl scaler_irq_ctrl_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .EDGE_MASK(EDGE_MASK)
) u_chk (
  .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .src_i(src_i), .ack_i(ack_i), .irq_o(irq_o), .irq_level_o(irq_level_o),
  .vec_valid_o(vec_valid_o), .en_q(en_q), .flag_q(flag_q),
  .cfg_roak(cfg_roak), .cfg_gen(cfg_gen)
);

// File: tb/tb_scaler_irq_ctrl.sv
module tb_scaler_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int N     = 8;
  localparam int LVLSRC = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [N-1:0] src_i = '0;
  logic        ack_i = 1'b0;
  logic        irq_o;
  logic [2:0]  irq_level_o;
  logic [7:0]  vec_o;
  logic        vec_valid_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  scaler_irq_ctrl dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .src_i(src_i), .ack_i(ack_i),
    .irq_o(irq_o), .irq_level_o(irq_level_o), .vec_o(vec_o), .vec_valid_o(vec_valid_o)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    tick();
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    rd_en_i = 1'b1; addr_i = a;
    tick();
    rd_en_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 irq", {31'd0, irq_o}, 0);
    check("R1 level", {29'd0, irq_level_o}, 0);
    check("R1 vec_valid", {31'd0, vec_valid_o}, 0);
    rd(2'd0, d); check("R1 cfg", d, 0);
    rd(2'd1, d); check("R1 csr", d, 0);

    // R2 config read-back, unused bits zero
    wr(2'd0, 32'hFFFF_FFFF); rd(2'd0, d); check("R2 all ones", d, 32'h0000_1FFF);
    wr(2'd0, 32'h0000_0A5C); rd(2'd0, d); check("R2 pattern", d, 32'h0000_0A5C);

    // R3 enable set / clear
    wr(2'd1, 32'h0000_00A5); rd(2'd1, d); check("R3 set", d, 32'h0000_00A5);
    wr(2'd1, 32'h0000_0500); rd(2'd1, d); check("R3 clear", d, 32'h0000_00A0);
    wr(2'd1, 32'h0000_FF00); rd(2'd1, d); check("R3 clear all", d, 0);

    // sweep: every source in both acknowledge modes
    for (int roak = 0; roak < 2; roak++) begin
      for (int n = 0; n < N; n++) begin
        logic [7:0]  vexp;
        logic [2:0]  lexp;
        logic [31:0] en_b, fl_b;
        vexp = 8'(8'h21 * (n + 1) + roak);
        lexp = 3'((n + roak) % 7 + 1);
        en_b = 32'(1) << n;
        fl_b = 32'(1) << (16 + n);
        wr(2'd0, (32'(roak) << 12) | (32'd1 << 11) | (32'(lexp) << 8) | 32'(vexp));
        wr(2'd1, en_b);
        src_i[n] = 1'b1;
        tick();
        if (n != LVLSRC) src_i[n] = 1'b0;
        tick();
        check($sformatf("R6 irq src%0d", n), {31'd0, irq_o}, 1);
        check($sformatf("R7 level src%0d", n), {29'd0, irq_level_o}, {29'd0, lexp});
        rd(2'd1, d);
        check($sformatf("R4 R12 status src%0d", n), d, en_b | fl_b | 32'h8000_0000);
        ack_i = 1'b1;
        tick();
        ack_i = 1'b0;
        check($sformatf("R8 strobe src%0d", n), {31'd0, vec_valid_o}, 1);
        check($sformatf("R8 vector src%0d", n), {24'd0, vec_o}, {24'd0, vexp});
        tick();
        check($sformatf("R8 strobe end src%0d", n), {31'd0, vec_valid_o}, 0);
        if (roak != 0) begin
          check($sformatf("R9 irq drop src%0d", n), {31'd0, irq_o}, 0);
          rd(2'd1, d); check($sformatf("R9 status src%0d", n), d, fl_b);
        end else begin
          check($sformatf("R10 irq held src%0d", n), {31'd0, irq_o}, 1);
          rd(2'd1, d); check($sformatf("R10 status src%0d", n), d, en_b | fl_b | 32'h8000_0000);
        end
        wr(2'd1, fl_b);
        if (n == LVLSRC) begin
          rd(2'd1, d);
          check("R5 clear refused", d & fl_b, fl_b);
          src_i[n] = 1'b0;
          tick(); tick();
        end else begin
          tick();
        end
        check($sformatf("R4 R5 R10 irq after clear src%0d", n), {31'd0, irq_o}, 0);
        rd(2'd1, d);
        check($sformatf("R4 R5 flag gone src%0d", n), d, (roak != 0) ? 32'd0 : en_b);
        wr(2'd1, 32'h0000_FF00);
      end
    end

    // R5 level flag follows input with one cycle delay
    src_i[LVLSRC] = 1'b1; tick(); src_i[LVLSRC] = 1'b0; tick();
    rd(2'd1, d); check("R5 follow low", d, 0);

    // R6 gating with a pending flag
    wr(2'd0, 32'h0000_0255);          // level 2, global enable off
    wr(2'd1, 32'h0000_0001);
    src_i[0] = 1'b1; tick(); src_i[0] = 1'b0; tick(); tick();
    check("R6 gen off", {31'd0, irq_o}, 0);
    wr(2'd0, 32'h0000_0855);          // global on, level 0
    tick();
    check("R6 level zero", {31'd0, irq_o}, 0);
    check("R7 level zero out", {29'd0, irq_level_o}, 0);
    wr(2'd0, 32'h0000_0A55);
    tick();
    check("R6 enabled", {31'd0, irq_o}, 1);
    check("R7 level two", {29'd0, irq_level_o}, 2);
    wr(2'd1, 32'h0001_FF00);
    tick();
    check("R6 cleared", {31'd0, irq_o}, 0);

    // R11 stray acknowledge
    wr(2'd0, 32'h0000_1A55);
    wr(2'd1, 32'h0000_00FF);
    ack_i = 1'b1; tick(); ack_i = 1'b0;
    check("R11 no strobe", {31'd0, vec_valid_o}, 0);
    tick();
    rd(2'd1, d); check("R11 enables kept", d, 32'h0000_00FF);

    finish_run();
  end
endmodule